// File: doc/BRIEF.md
# Carry-Completion Ripple Adder Group

This block adds operand pairs in several parallel lanes. Each lane is a ripple carry adder whose carry chain advances by one bit position per clock. For every position the lane records whether the carry out of that position is already settled. Positions with two equal operand bits settle on the first step. A position with different operand bits passes the carry it receives, so it settles one step after the position below it. A lane finishes as soon as every position has settled. Its latency therefore follows the longest stretch of carry-passing positions and only reaches WIDTH steps in the worst case.

A small group controller accepts a shared start strobe only while no lane is running. It reports the group as done once every lane is done, and it reports the largest lane step count. After a lane finishes, its sum, carry-out and step count stay fixed until the next accepted start. Operands for lane k sit in bits [k*WIDTH +: WIDTH] of the flat operand buses. Step counts for lane k sit in bits [k*CW +: CW], where CW = clog2(WIDTH+1).

Top module: `ccadd_group`

## Requirements
- R1: When a lane's done flag is high, its carry-out concatenated with its sum equals A + B + carry-in. These are the operands captured at the accepted start, with lane k's fields at bits [k*WIDTH +: WIDTH].
- R2: A position whose two operand bits are equal settles on step 1. Its carry value is that operand bit.
- R3: A position whose operand bits differ settles one step after the position below it. Bit 0 counts the carry-in as settled at step 0. The settle step is therefore s(i) = s(i-1)+1, with s(-1) = 0.
- R4: A lane's step count equals S, the largest s(i) over all positions. S is at least 1 and never exceeds WIDTH.
- R5: A lane's done flag rises on the (S+1)-th rising edge after the edge that accepted start. From then on, done, sum, carry-out and the step count hold until the next accepted start.
- R6: A start that arrives while any lane is running is ignored. No operands are captured, and the running results are not disturbed.
- R7: The group done output is high exactly when every lane's done flag is high. The busy output is high while any lane is running, and done and busy are never high together.
- R8: The group step count equals the largest step count among the lanes.
- R9: Once a position has settled, its carry value stays unchanged until the next accepted start.
- R10: After reset, done, busy, the step counts, the sums and the carry-outs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe shared by all lanes |
| cin_i | input | LANES | Carry-in per lane |
| a_i | input | LANES*WIDTH | First operands, lane k at [k*WIDTH +: WIDTH] |
| b_i | input | LANES*WIDTH | Second operands, same packing |
| sum_o | output | LANES*WIDTH | Sums, same packing |
| cout_o | output | LANES | Carry-out per lane |
| lane_done_o | output | LANES | Per-lane completion flag |
| lane_cycles_o | output | LANES*CW | Per-lane step count |
| done_o | output | 1 | All lanes complete |
| busy_o | output | 1 | At least one lane running |
| group_cycles_o | output | CW | Largest lane step count |

## Verification
The assertions assume that start is the only input that changes a lane's captured state. They also assume that start and step never reach a bit cell on the same edge, because the lane steps only while running and loads only while not running. The sum check assumes the captured operands do not change during a run. The stimulus changes operands and carry-ins only at falling edges. It also drives a second start in the middle of a long run, so the ignore path is exercised without breaking these assumptions.

// File: rtl/ccadd_pkg.sv
package ccadd_pkg;
   typedef enum logic [1:0] {
      LN_IDLE = 2'd0,
      LN_RUN  = 2'd1,
      LN_DONE = 2'd2
   } lane_state_e;
endpackage

// File: rtl/cca_bit_cell.sv
module cca_bit_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic step_i,
   input  logic a_i,
   input  logic b_i,
   input  logic low_res_i,
   input  logic low_val_i,
   output logic res_o,
   output logic val_o
);
   logic same_bits;
   assign same_bits = (a_i == b_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o <= 1'b0;
         val_o <= 1'b0;
      end else if (load_i) begin
         res_o <= 1'b0;
         val_o <= 1'b0;
      end else if (step_i && !res_o) begin
         if (same_bits) begin
            res_o <= 1'b1;
            val_o <= a_i;
         end else if (low_res_i) begin
            res_o <= 1'b1;
            val_o <= low_val_i;
         end
      end
   end

   AST_GK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !res_o && same_bits) |=> (res_o && val_o == $past(a_i))); // R2
   AST_PROP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !res_o && !same_bits && !low_res_i) |=> !res_o); // R3
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_o && !load_i) |=> (res_o && $stable(val_o))); // R9
endmodule

// File: rtl/cca_lane.sv
module cca_lane
   import ccadd_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int CW    = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             done_o,
   output logic             busy_o,
   output logic [CW-1:0]    cycles_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("cca_lane: WIDTH must be at least 2");
   end
   if ((1 << CW) <= WIDTH) begin : g_bad_cw
      $error("cca_lane: CW too narrow for WIDTH");
   end

   lane_state_e      st;
   logic [WIDTH-1:0] a_q, b_q;
   logic             cin_q;
   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] res, val;
   logic             all_res, load, step;

   assign all_res = &res;
   assign load    = start_i && (st != LN_RUN);
   assign step    = (st == LN_RUN) && !all_res;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic lo_res, lo_val;
      if (i == 0) begin : g_base
         assign lo_res = 1'b1;
         assign lo_val = cin_q;
      end else begin : g_chain
         assign lo_res = res[i-1];
         assign lo_val = val[i-1];
      end
      cca_bit_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load),
         .step_i    (step),
         .a_i       (a_q[i]),
         .b_i       (b_q[i]),
         .low_res_i (lo_res),
         .low_val_i (lo_val),
         .res_o     (res[i]),
         .val_o     (val[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= LN_IDLE;
         a_q   <= '0;
         b_q   <= '0;
         cin_q <= 1'b0;
         cnt   <= '0;
      end else if (load) begin
         st    <= LN_RUN;
         a_q   <= a_i;
         b_q   <= b_i;
         cin_q <= cin_i;
         cnt   <= '0;
      end else if (st == LN_RUN) begin
         if (all_res) st <= LN_DONE;
         else         cnt <= cnt + CW'(1);
      end
   end

   assign sum_o    = a_q ^ b_q ^ {val[WIDTH-2:0], cin_q};
   assign cout_o   = val[WIDTH-1];
   assign done_o   = (st == LN_DONE);
   assign busy_o   = (st == LN_RUN);
   assign cycles_o = cnt;

   AST_SUM_OK: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ({cout_o, sum_o} ==
                  ({1'b0, a_q} + {1'b0, b_q} + (WIDTH+1)'(cin_q)))); // R1
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(WIDTH)); // R4
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q))); // R6
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(sum_o) && $stable(cnt))); // R5
endmodule

// File: rtl/cca_join.sv
module cca_join #(
   parameter int LANES = 2,
   parameter int CW    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [LANES-1:0]    lane_done_i,
   input  logic [LANES-1:0]    lane_busy_i,
   input  logic [LANES*CW-1:0] lane_cycles_i,
   output logic                go_o,
   output logic                done_o,
   output logic                busy_o,
   output logic [CW-1:0]       max_cycles_o
);
   if (LANES < 1) begin : g_bad_lanes
      $error("cca_join: LANES must be at least 1");
   end

   assign busy_o = |lane_busy_i;
   assign done_o = &lane_done_i;
   assign go_o   = start_i && !busy_o;

   always_comb begin
      max_cycles_o = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane_cycles_i[k*CW +: CW] > max_cycles_o)
            max_cycles_o = lane_cycles_i[k*CW +: CW];
      end
   end

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R7
   AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o); // R5
endmodule

// File: rtl/ccadd_group.sv
module ccadd_group #(
   parameter int WIDTH = 16,
   parameter int LANES = 2,
   localparam int CW   = $clog2(WIDTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LANES-1:0]       cin_i,
   input  logic [LANES*WIDTH-1:0] a_i,
   input  logic [LANES*WIDTH-1:0] b_i,
   output logic [LANES*WIDTH-1:0] sum_o,
   output logic [LANES-1:0]       cout_o,
   output logic [LANES-1:0]       lane_done_o,
   output logic [LANES*CW-1:0]    lane_cycles_o,
   output logic                   done_o,
   output logic                   busy_o,
   output logic [CW-1:0]          group_cycles_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("ccadd_group: WIDTH must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("ccadd_group: LANES must be at least 1");
   end

   logic             go;
   logic [LANES-1:0] lane_busy;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      cca_lane #(.WIDTH(WIDTH), .CW(CW)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .start_i  (go),
         .a_i      (a_i[k*WIDTH +: WIDTH]),
         .b_i      (b_i[k*WIDTH +: WIDTH]),
         .cin_i    (cin_i[k]),
         .sum_o    (sum_o[k*WIDTH +: WIDTH]),
         .cout_o   (cout_o[k]),
         .done_o   (lane_done_o[k]),
         .busy_o   (lane_busy[k]),
         .cycles_o (lane_cycles_o[k*CW +: CW])
      );

      AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
         lane_cycles_o[k*CW +: CW] <= group_cycles_o); // R8
   end

   cca_join #(.LANES(LANES), .CW(CW)) u_join (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .lane_done_i   (lane_done_o),
      .lane_busy_i   (lane_busy),
      .lane_cycles_i (lane_cycles_o),
      .go_o          (go),
      .done_o        (done_o),
      .busy_o        (busy_o),
      .max_cycles_o  (group_cycles_o)
   );

   AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (go && busy_o) |-> 1'b0); // R6
endmodule

// File: tb/ccadd_group_bench.sv
module ccadd_group_bench;
   localparam int PERIOD = 10;
   localparam int W      = 8;
   localparam int NL     = 2;
   localparam int CW     = $clog2(W + 1);

   typedef struct packed {
      logic [W-1:0] a0;
      logic [W-1:0] b0;
      logic         c0;
      logic [W-1:0] a1;
      logic [W-1:0] b1;
      logic         c1;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{8'h00, 8'h00, 1'b0, 8'hFF, 8'hFF, 1'b1},
      '{8'hFF, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0},
      '{8'h0F, 8'h01, 1'b0, 8'h55, 8'hAA, 1'b0},
      '{8'h7F, 8'h01, 1'b0, 8'h80, 8'h80, 1'b1},
      '{8'hA5, 8'h5A, 1'b1, 8'h3C, 8'h0F, 1'b0},
      '{8'h12, 8'h34, 1'b1, 8'hFE, 8'h01, 1'b1},
      '{8'h01, 8'h00, 1'b1, 8'h80, 8'h7F, 1'b0},
      '{8'hC3, 8'h3C, 1'b0, 8'h0F, 8'hF0, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [NL-1:0]     cin_i = '0;
   logic [NL*W-1:0]   a_i = '0;
   logic [NL*W-1:0]   b_i = '0;
   logic [NL*W-1:0]   sum_o;
   logic [NL-1:0]     cout_o;
   logic [NL-1:0]     lane_done_o;
   logic [NL*CW-1:0]  lane_cycles_o;
   logic              done_o;
   logic              busy_o;
   logic [CW-1:0]     group_cycles_o;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   ccadd_group #(.WIDTH(W), .LANES(NL)) u_ccadd_group (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .cin_i          (cin_i),
      .a_i            (a_i),
      .b_i            (b_i),
      .sum_o          (sum_o),
      .cout_o         (cout_o),
      .lane_done_o    (lane_done_o),
      .lane_cycles_o  (lane_cycles_o),
      .done_o         (done_o),
      .busy_o         (busy_o),
      .group_cycles_o (group_cycles_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // settle-step model: equal bits settle at step 1, differing bits one after the lower position
   function automatic int steps_of(input logic [W-1:0] a, input logic [W-1:0] b);
      int prev = 0;
      int mx = 0;
      for (int i = 0; i < W; i++) begin
         int s;
         s = (a[i] != b[i]) ? prev + 1 : 1;
         prev = s;
         if (s > mx) mx = s;
      end
      return mx;
   endfunction

   task automatic drive(input vec_t v);
      a_i     = {v.a1, v.a0};
      b_i     = {v.b1, v.b0};
      cin_i   = {v.c1, v.c0};
   endtask

   task automatic launch(input vec_t v);
      drive(v);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_and_check(input vec_t v, input string tag);
      int s0, s1, smax, n;
      logic [W:0] e0, e1;
      s0   = steps_of(v.a0, v.b0);
      s1   = steps_of(v.a1, v.b1);
      smax = (s0 > s1) ? s0 : s1;
      e0   = {1'b0, v.a0} + {1'b0, v.b0} + (W+1)'(v.c0);
      e1   = {1'b0, v.a1} + {1'b0, v.b1} + (W+1)'(v.c1);
      n = 0;
      do begin
         @(posedge clk);
         @(negedge clk);
         n++;
         check({"R5 lane0 done timing ", tag}, 32'(lane_done_o[0]), 32'(n >= s0 + 1));
         check({"R5 lane1 done timing ", tag}, 32'(lane_done_o[1]), 32'(n >= s1 + 1));
      end while (!done_o && n < W + 4);
      check({"R5/R7 group latency ", tag}, 32'(n), 32'(smax + 1));
      check({"R1 lane0 sum ", tag}, 32'({cout_o[0], sum_o[W-1:0]}), 32'(e0));
      check({"R1 lane1 sum ", tag}, 32'({cout_o[1], sum_o[2*W-1:W]}), 32'(e1));
      // R2 R3 R4: step count equals the settle-step maximum
      check({"R4 lane0 steps ", tag}, 32'(lane_cycles_o[CW-1:0]), 32'(s0));
      check({"R4 lane1 steps ", tag}, 32'(lane_cycles_o[2*CW-1:CW]), 32'(s1));
      check({"R8 group steps ", tag}, 32'(group_cycles_o), 32'(smax));
      check({"R7 not busy at done ", tag}, 32'(busy_o), 32'd0);
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 done", 32'(done_o), 32'd0);
      check("R10 busy", 32'(busy_o), 32'd0);
      check("R10 lane done", 32'(lane_done_o), 32'd0);
      check("R10 sum", 32'(sum_o), 32'd0);
      check("R10 cout", 32'(cout_o), 32'd0);
      check("R10 steps", 32'(lane_cycles_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         launch(VEC[i]);
         finish_and_check(VEC[i], $sformatf("vec%0d", i));
      end

      // R6: start during a long run is ignored (lane0 all propagate, WIDTH steps)
      begin
         vec_t longv, other;
         longv = '{8'hFF, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0};
         other = '{8'h11, 8'h22, 1'b0, 8'h33, 8'h44, 1'b1};
         launch(longv);
         @(negedge clk);
         @(negedge clk);
         check("R7 busy mid run", 32'(busy_o), 32'd1);
         launch(other);
         drive(other);
         // latency is measured from the first start: 3 edges already elapsed
         begin
            int n;
            n = 3;
            while (!done_o && n < W + 6) begin
               @(posedge clk);
               @(negedge clk);
               n++;
            end
            check("R6 latency from first start", 32'(n), 32'(W + 1));
         end
         check("R6 lane0 result kept", 32'({cout_o[0], sum_o[W-1:0]}), 32'h100);
         check("R6 lane1 result kept", 32'({cout_o[1], sum_o[2*W-1:W]}), 32'h000);
         check("R4 worst case steps", 32'(lane_cycles_o[CW-1:0]), 32'(W));

         // R5/R9: results held with new inputs present and start low
         repeat (4) @(negedge clk);
         check("R5 done held", 32'(done_o), 32'd1);
         check("R9 sum held", 32'(sum_o), 32'h0000);
         check("R5 cout held", 32'(cout_o), 32'b01);
         check("R5 steps held", 32'(group_cycles_o), 32'(W));

         // a start after completion is accepted
         launch(other);
         finish_and_check(other, "restart");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule